// File: doc/BRIEF.md
# MOSI Snooping Line Controller

This block keeps the coherence state of every line of a small direct-mapped cache that sits on a shared snooping bus. It follows the four-state MOSI protocol: Invalid, Shared, Owned and Modified. The processor side presents one request at a time: load, store or evict. The controller checks the request against the stored tag and state. It then either finishes the request at once or asks a bus arbiter for the bus so that it can issue a read-for-sharing, a read-for-ownership, a dataless invalidate or a writeback.

The controller also watches the transactions that other caches place on the bus. A snooped transaction that hits a valid line changes that line's state. When this cache holds the only dirty copy, the controller raises a data-supply strobe together with its own driver id, so the requester takes the data from this cache and not from memory. Memory uses driver id 0 and each cache has its own non-zero id.

The Owned state keeps a dirty copy in the cache after the line has been passed to another cache, so such a transfer costs no memory writeback. A store to a line in S or O needs only an invalidate, with no data transfer. While a processor request waits for the grant, it is evaluated again on every cycle, so a snoop that changes the line's state also changes the command being requested.

Top module: `mosiSnoopCtrl`

## Requirements
- R1: After reset every line is Invalid. The outputs busReq, cpuDone and dataValid are low while no request and no snoop is presented.
- R2: A load to a line in I drives busReq with command 1 (read-for-sharing) and leaves the line in S once granted. A load that hits S, O or M raises cpuDone in the same cycle with busReq low.
- R3: A store to a line in I requests command 2 (read-for-ownership). A store to a line in S or O requests command 3 (invalidate). Either one leaves the line in M once granted. A store that hits M completes in the same cycle with busReq low.
- R4: Evicting a line in M or O requests command 4 (writeback) and leaves the line in I once granted. Evicting a line in S, or an address that misses, completes at once with no bus request, and the line ends in I.
- R5: A snooped read-for-sharing (snoopCmd 1) that hits M moves the line to O and supplies the data. One that hits O supplies the data and keeps O. One that hits S supplies nothing and keeps S.
- R6: A snooped read-for-ownership (snoopCmd 2) that hits M or O supplies the data. One that hits S supplies nothing. In every one of these cases the line ends in I.
- R7: A snooped invalidate (snoopCmd 3) that hits S or O moves the line to I.
- R8: In a cycle where snoopValid is high, no processor request completes: cpuDone stays low, even when busGnt is high.
- R9: While a request waits for the grant, its command follows the current line state. A pending invalidate becomes a read-for-ownership once a snoop has invalidated the line.
- R10: A load or store whose index holds a line in M or O with another tag first requests a writeback (command 4) with busAddr set to the victim's address, without raising cpuDone. Only after that does it request the fill at the processor address. A victim in S is dropped without a bus transaction.
- R11: dataValid is high for exactly the one cycle after a snoop that hits M or O and asks for data. In that cycle dataId equals this cache's id (1 by default). At all other times dataId is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuOp | input | 2 | Processor request: 0 none, 1 load, 2 store, 3 evict |
| cpuAddr | input | ADDR_W | Processor line address |
| cpuBusy | output | 1 | Request is waiting for a bus grant |
| cpuDone | output | 1 | Request completes at the coming clock edge |
| busReq | output | 1 | Request to the bus arbiter |
| busGnt | input | 1 | Grant from the bus arbiter |
| busCmd | output | 3 | Command of the pending transaction: 0 none, 1 read-share, 2 read-own, 3 invalidate, 4 writeback |
| busAddr | output | ADDR_W | Address of the pending transaction (victim or processor address) |
| snoopValid | input | 1 | A transaction from another cache is on the bus |
| snoopCmd | input | 3 | Command of the snooped transaction, same encoding as busCmd |
| snoopAddr | input | ADDR_W | Address of the snooped transaction |
| dataValid | output | 1 | This cache drives the data for the last snooped transaction |
| dataId | output | ID_W | Driver id when dataValid is high, otherwise 0 |

## Verification
The assertions check the rules that hold on every cycle: a snoop always blocks processor completion, a hit in S, O or M never requests the bus on a load, a store to M is always silent, a bus request always carries a command, and the supply strobe only ever follows a snoop that hit a dirty line. The bench scenarios are needed for the sequences that span several cycles. These are the state a line reaches after a granted transaction, the way a pending request switches its command after a snoop, the victim writeback followed by the fill, and the clearing of dirty state by reset. Line state is not visible at the ports, so the bench reads it back through the command that a later probing request produces.

// File: rtl/mosiPkg.sv
package mosiPkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_OWN = 2'd2,
    LS_MOD = 2'd3
  } lineState_t;

  typedef enum logic [2:0] {
    BC_NONE  = 3'd0,
    BC_RDSH  = 3'd1,
    BC_RDEX  = 3'd2,
    BC_INVAL = 3'd3,
    BC_WBACK = 3'd4
  } busCmd_t;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_EVICT = 2'd3
  } cpuOp_t;

  // Strobes from the control to the line store
  typedef struct packed {
    logic       cpuWr;    // write state at the processor index
    logic       cpuFill;  // load the processor tag at that index
    lineState_t cpuNext;
    logic       snpWr;    // write state at the snooped index
    lineState_t snpNext;
    logic       supply;   // drive data for this snoop next cycle
  } lineStrobe_t;

endpackage

// File: rtl/mosiLineStore.sv
module mosiLineStore
  import mosiPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 2,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  lineStrobe_t       strb,
  output lineState_t        cpuState,
  output lineState_t        victimState,
  output logic [ADDR_W-1:0] victimAddr,
  output lineState_t        snpState,
  output logic              dataValid,
  output logic [ID_W-1:0]   dataId
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  lineState_t       stateArr [LINES];
  logic [TAG_W-1:0] tagArr   [LINES];
  logic             supplyReg;

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             cpuTagHit, snpTagHit;

  assign cpuIdx = cpuAddr[IDX_W-1:0];
  assign cpuTag = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx = snoopAddr[IDX_W-1:0];
  assign snpTag = snoopAddr[ADDR_W-1:IDX_W];

  assign cpuTagHit = (tagArr[cpuIdx] == cpuTag);
  assign snpTagHit = (tagArr[snpIdx] == snpTag);

  // Tag compare: a mismatch looks Invalid to the requester
  assign cpuState    = cpuTagHit ? stateArr[cpuIdx] : LS_INV;
  assign victimState = cpuTagHit ? LS_INV : stateArr[cpuIdx];
  assign victimAddr  = {tagArr[cpuIdx], cpuIdx};
  assign snpState    = snpTagHit ? stateArr[snpIdx] : LS_INV;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LINES; i++) begin
        stateArr[i] <= LS_INV;
        tagArr[i]   <= '0;
      end
      supplyReg <= 1'b0;
    end else begin
      if (strb.cpuWr)   stateArr[cpuIdx] <= strb.cpuNext;
      if (strb.cpuFill) tagArr[cpuIdx]   <= cpuTag;
      if (strb.snpWr)   stateArr[snpIdx] <= strb.snpNext;
      supplyReg <= strb.supply;
    end
  end

  assign dataValid = supplyReg;
  assign dataId    = supplyReg ? ID_W'(MY_ID) : '0;

  AST_SUPPLY_FROM_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.supply |-> (snpState == LS_MOD || snpState == LS_OWN)) else $error("supply from clean line"); // R11

  AST_CPU_SNOOP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cpuWr && strb.snpWr)) else $error("processor and snoop update in one cycle"); // R8

endmodule

// File: rtl/mosiCoherCtl.sv
module mosiCoherCtl
  import mosiPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cpuOp_t      cpuOp,
  input  lineState_t  cpuState,
  input  lineState_t  victimState,
  input  logic        busGnt,
  input  logic        snoopValid,
  input  busCmd_t     snoopCmd,
  input  lineState_t  snpState,
  output logic        busReq,
  output busCmd_t     busCmdOut,
  output logic        useVictim,
  output logic        cpuDone,
  output lineStrobe_t strb
);

  busCmd_t    needCmd;
  lineState_t nextState;
  logic       needWr, needFill, victimStep, victimDirty, go;

  assign victimDirty = (victimState == LS_MOD) || (victimState == LS_OWN);

  // Request decode, evaluated again on every cycle from the current state
  always_comb begin
    needCmd    = BC_NONE;
    nextState  = cpuState;
    needWr     = 1'b0;
    needFill   = 1'b0;
    victimStep = 1'b0;
    unique case (cpuOp)
      OP_LOAD: begin
        if (cpuState == LS_INV) begin
          if (victimDirty) begin
            needCmd = BC_WBACK; victimStep = 1'b1;
            needWr = 1'b1; nextState = LS_INV;
          end else begin
            needCmd = BC_RDSH; needWr = 1'b1; needFill = 1'b1; nextState = LS_SHR;
          end
        end
      end
      OP_STORE: begin
        unique case (cpuState)
          LS_INV: begin
            if (victimDirty) begin
              needCmd = BC_WBACK; victimStep = 1'b1;
              needWr = 1'b1; nextState = LS_INV;
            end else begin
              needCmd = BC_RDEX; needWr = 1'b1; needFill = 1'b1; nextState = LS_MOD;
            end
          end
          LS_SHR, LS_OWN: begin
            needCmd = BC_INVAL; needWr = 1'b1; nextState = LS_MOD;
          end
          default: ;
        endcase
      end
      OP_EVICT: begin
        unique case (cpuState)
          LS_MOD, LS_OWN: begin needCmd = BC_WBACK; needWr = 1'b1; nextState = LS_INV; end
          LS_SHR:         begin needWr = 1'b1; nextState = LS_INV; end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  assign busReq    = (cpuOp != OP_NONE) && (needCmd != BC_NONE);
  assign busCmdOut = busReq ? needCmd : BC_NONE;
  assign useVictim = victimStep;
  // Snoop has priority: no processor step in a snoop cycle
  assign go        = (cpuOp != OP_NONE) && !snoopValid && (needCmd == BC_NONE || busGnt);
  assign cpuDone   = go && !victimStep;

  // Snoop decode
  always_comb begin
    strb.snpWr   = 1'b0;
    strb.snpNext = snpState;
    strb.supply  = 1'b0;
    if (snoopValid && snpState != LS_INV) begin
      unique case (snoopCmd)
        BC_RDSH: if (snpState == LS_MOD || snpState == LS_OWN) begin
          strb.snpWr = 1'b1; strb.snpNext = LS_OWN; strb.supply = 1'b1;
        end
        BC_RDEX: begin
          strb.snpWr = 1'b1; strb.snpNext = LS_INV;
          strb.supply = (snpState == LS_MOD) || (snpState == LS_OWN);
        end
        BC_INVAL: if (snpState == LS_SHR || snpState == LS_OWN) begin
          strb.snpWr = 1'b1; strb.snpNext = LS_INV;
        end
        default: ;
      endcase
    end
  end

  assign strb.cpuWr   = go && needWr;
  assign strb.cpuFill = go && needFill;
  assign strb.cpuNext = nextState;

  AST_SNOOP_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    snoopValid |-> !cpuDone) else $error("completion during snoop"); // R8

  AST_LOAD_HIT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cpuOp == OP_LOAD && cpuState != LS_INV) |-> (!busReq && (cpuDone || snoopValid))) else $error("load hit used bus"); // R2

  AST_MOD_STORE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (cpuOp == OP_STORE && cpuState == LS_MOD) |-> !busReq) else $error("store to M used bus"); // R3

  AST_VICTIM_NOT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busCmdOut == BC_WBACK && cpuOp != OP_EVICT) |-> !cpuDone) else $error("victim step completed request"); // R10

endmodule

// File: rtl/mosiSnoopCtrl.sv
module mosiSnoopCtrl
  import mosiPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 2,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cpuOp,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              cpuBusy,
  output logic              cpuDone,
  output logic              busReq,
  input  logic              busGnt,
  output logic [2:0]        busCmd,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              snoopValid,
  input  logic [2:0]        snoopCmd,
  input  logic [ADDR_W-1:0] snoopAddr,
  output logic              dataValid,
  output logic [ID_W-1:0]   dataId
);

  lineStrobe_t       strb;
  lineState_t        cpuState, victimState, snpState;
  logic [ADDR_W-1:0] victimAddr;
  busCmd_t           cmdOut;
  logic              useVictim;

  mosiLineStore #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_store (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .snoopAddr(snoopAddr), .strb(strb),
    .cpuState(cpuState), .victimState(victimState), .victimAddr(victimAddr),
    .snpState(snpState), .dataValid(dataValid), .dataId(dataId)
  );

  mosiCoherCtl u_ctl (
    .clk(clk), .rstN(rstN), .cpuOp(cpuOp_t'(cpuOp)), .cpuState(cpuState),
    .victimState(victimState), .busGnt(busGnt), .snoopValid(snoopValid),
    .snoopCmd(busCmd_t'(snoopCmd)), .snpState(snpState), .busReq(busReq),
    .busCmdOut(cmdOut), .useVictim(useVictim), .cpuDone(cpuDone), .strb(strb)
  );

  assign busCmd  = cmdOut;
  assign busAddr = useVictim ? victimAddr : cpuAddr;
  assign cpuBusy = busReq && !cpuDone;

  AST_REQ_HAS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busCmd != 3'd0)) else $error("request without command"); // R2

endmodule

// File: tb/mosiSnoopCtrl_bench.sv
module mosiSnoopCtrl_bench;

  localparam logic [1:0]  ON = 2'd0, OL = 2'd1, OS = 2'd2, OE = 2'd3;
  localparam logic [2:0]  C0 = 3'd0, CRS = 3'd1, CRX = 3'd2, CIV = 3'd3, CWB = 3'd4;
  localparam logic [11:0] AA = 12'h010, CC = 12'h005, EE = 12'h015, DD = 12'h006, FF = 12'h00A, Z = 12'h000;

  typedef struct packed {
    logic [1:0]  op;   logic [11:0] addr;
    logic        sv;   logic [2:0]  scmd; logic [11:0] saddr;
    logic        gnt;
    logic        eReq; logic [2:0]  eCmd; logic eDone; logic eSup;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    '{ON, Z,  1'b0, C0,  Z,  1'b0, 1'b0, C0,  1'b0, 1'b0, 4'd1},  // 0  R1 idle after reset
    '{OL, AA, 1'b0, C0,  Z,  1'b0, 1'b1, CRS, 1'b0, 1'b0, 4'd2},  // 1  R2 load miss requests
    '{OL, AA, 1'b0, C0,  Z,  1'b1, 1'b1, CRS, 1'b1, 1'b0, 4'd2},  // 2  R2 granted -> S
    '{OL, AA, 1'b0, C0,  Z,  1'b0, 1'b0, C0,  1'b1, 1'b0, 4'd2},  // 3  R2 hit in S
    '{OS, AA, 1'b0, C0,  Z,  1'b0, 1'b1, CIV, 1'b0, 1'b0, 4'd3},  // 4  R3 S store -> inval
    '{OS, AA, 1'b0, C0,  Z,  1'b1, 1'b1, CIV, 1'b1, 1'b0, 4'd3},  // 5  R3 granted -> M
    '{OS, AA, 1'b0, C0,  Z,  1'b0, 1'b0, C0,  1'b1, 1'b0, 4'd3},  // 6  R3 M silent
    '{ON, Z,  1'b1, CRS, AA, 1'b0, 1'b0, C0,  1'b0, 1'b0, 4'd5},  // 7  R5 snoop share on M
    '{ON, Z,  1'b0, C0,  Z,  1'b0, 1'b0, C0,  1'b0, 1'b1, 4'd11}, // 8  R11 supply one cycle later
    '{OS, AA, 1'b0, C0,  Z,  1'b0, 1'b1, CIV, 1'b0, 1'b0, 4'd5},  // 9  R5 line now O
    '{ON, Z,  1'b1, CRS, AA, 1'b0, 1'b0, C0,  1'b0, 1'b0, 4'd5},  // 10 R5 snoop share on O
    '{OE, AA, 1'b0, C0,  Z,  1'b0, 1'b1, CWB, 1'b0, 1'b1, 4'd5},  // 11 R5 O supplied, R4 evict wb
    '{OE, AA, 1'b0, C0,  Z,  1'b1, 1'b1, CWB, 1'b1, 1'b0, 4'd4},  // 12 R4 granted -> I
    '{OS, AA, 1'b0, C0,  Z,  1'b0, 1'b1, CRX, 1'b0, 1'b0, 4'd4},  // 13 R4 line was left I
    '{OS, AA, 1'b0, C0,  Z,  1'b1, 1'b1, CRX, 1'b1, 1'b0, 4'd3},  // 14 R3 I store -> M
    '{OS, AA, 1'b1, CRX, AA, 1'b0, 1'b0, C0,  1'b0, 1'b0, 4'd8},  // 15 R8 snoop blocks hit
    '{OS, AA, 1'b0, C0,  Z,  1'b0, 1'b1, CRX, 1'b0, 1'b1, 4'd6},  // 16 R6 M supplied, now I
    '{OL, CC, 1'b0, C0,  Z,  1'b1, 1'b1, CRS, 1'b1, 1'b0, 4'd2},  // 17 R2 C -> S
    '{ON, Z,  1'b1, CRX, CC, 1'b0, 1'b0, C0,  1'b0, 1'b0, 4'd6},  // 18 R6 snoop own on S
    '{OL, CC, 1'b0, C0,  Z,  1'b0, 1'b1, CRS, 1'b0, 1'b0, 4'd6},  // 19 R6 S gave no data, now I
    '{OL, CC, 1'b0, C0,  Z,  1'b1, 1'b1, CRS, 1'b1, 1'b0, 4'd2},  // 20 R2 C -> S
    '{OS, CC, 1'b1, CIV, CC, 1'b0, 1'b1, CIV, 1'b0, 1'b0, 4'd7},  // 21 R7 snoop inval while pending
    '{OS, CC, 1'b0, C0,  Z,  1'b0, 1'b1, CRX, 1'b0, 1'b0, 4'd9},  // 22 R9 pending cmd re-evaluated
    '{OS, CC, 1'b0, C0,  Z,  1'b1, 1'b1, CRX, 1'b1, 1'b0, 4'd3},  // 23 R3 C -> M
    '{OL, EE, 1'b0, C0,  Z,  1'b0, 1'b1, CWB, 1'b0, 1'b0, 4'd10}, // 24 R10 dirty victim wb first
    '{OL, EE, 1'b0, C0,  Z,  1'b1, 1'b1, CWB, 1'b0, 1'b0, 4'd10}, // 25 R10 victim step not done
    '{OL, EE, 1'b0, C0,  Z,  1'b0, 1'b1, CRS, 1'b0, 1'b0, 4'd10}, // 26 R10 then the fill
    '{OL, EE, 1'b0, C0,  Z,  1'b1, 1'b1, CRS, 1'b1, 1'b0, 4'd2},  // 27 R2 E -> S
    '{OL, CC, 1'b0, C0,  Z,  1'b0, 1'b1, CRS, 1'b0, 1'b0, 4'd10}, // 28 R10 clean victim dropped
    '{ON, Z,  1'b0, C0,  Z,  1'b0, 1'b0, C0,  1'b0, 1'b0, 4'd1}   // 29 R1 quiet
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cpuOp = '0;
  logic [11:0] cpuAddr = '0;
  logic        busGnt = 1'b0;
  logic        snoopValid = 1'b0;
  logic [2:0]  snoopCmd = '0;
  logic [11:0] snoopAddr = '0;
  logic        cpuBusy, cpuDone, busReq, dataValid;
  logic [2:0]  busCmd;
  logic [11:0] busAddr;
  logic [1:0]  dataId;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  mosiSnoopCtrl u_mosiSnoopCtrl (
    .clk(clk), .rstN(rstN), .cpuOp(cpuOp), .cpuAddr(cpuAddr), .cpuBusy(cpuBusy),
    .cpuDone(cpuDone), .busReq(busReq), .busGnt(busGnt), .busCmd(busCmd),
    .busAddr(busAddr), .snoopValid(snoopValid), .snoopCmd(snoopCmd),
    .snoopAddr(snoopAddr), .dataValid(dataValid), .dataId(dataId)
  );

  // Drive at the falling edge, sample just before the next rising edge
  task automatic step(input logic [1:0] op, input logic [11:0] a, input logic sv,
                      input logic [2:0] sc, input logic [11:0] sa, input logic g);
    @(negedge clk);
    cpuOp = op; cpuAddr = a; snoopValid = sv; snoopCmd = sc; snoopAddr = sa; busGnt = g;
    #4;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input logic r, input logic [2:0] c,
                           input logic d, input logic s);
    check(req, {busReq, 1'b0, busCmd, 1'b0, cpuDone, 1'b0, dataValid},
               {r, 1'b0, c, 1'b0, d, 1'b0, s});
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].op, TBL[i].addr, TBL[i].sv, TBL[i].scmd, TBL[i].saddr, TBL[i].gnt);
      checkOuts($sformatf("R%0d row%0d", TBL[i].rq, i), TBL[i].eReq, TBL[i].eCmd,
                TBL[i].eDone, TBL[i].eSup);
    end

    // R11: supply strobe carries this cache's id for one cycle
    step(OS, DD, 1'b0, C0, Z, 1'b1);
    step(ON, Z, 1'b1, CRS, DD, 1'b0);
    check("R11 no data yet", {31'd0, dataValid}, 32'd0);
    step(ON, Z, 1'b0, C0, Z, 1'b0);
    check("R11 id", {29'd0, dataValid, dataId}, {29'd0, 1'b1, 2'd1});
    step(ON, Z, 1'b0, C0, Z, 1'b0);
    check("R11 one cycle", {29'd0, dataValid, dataId}, 32'd0);

    // R10: victim writeback carries the victim address, then the fill address
    step(OL, FF, 1'b0, C0, Z, 1'b0);
    check("R10 victim addr", {17'd0, busCmd, busAddr}, {17'd0, CWB, DD});
    step(OL, FF, 1'b0, C0, Z, 1'b1);
    step(OL, FF, 1'b0, C0, Z, 1'b0);
    check("R10 fill addr", {17'd0, busCmd, busAddr}, {17'd0, CRS, FF});
    step(OL, FF, 1'b0, C0, Z, 1'b1);

    // R5: snoop share on S supplies nothing and keeps S
    step(ON, Z, 1'b1, CRS, FF, 1'b0);
    step(OL, FF, 1'b0, C0, Z, 1'b0);
    checkOuts("R5 S kept, no data", 1'b0, C0, 1'b1, 1'b0);

    // R4: evict of S and of a missing line are silent
    step(OE, FF, 1'b0, C0, Z, 1'b0);
    checkOuts("R4 evict S", 1'b0, C0, 1'b1, 1'b0);
    step(OE, FF, 1'b0, C0, Z, 1'b0);
    checkOuts("R4 evict miss", 1'b0, C0, 1'b1, 1'b0);
    step(OL, FF, 1'b0, C0, Z, 1'b0);
    checkOuts("R4 line now I", 1'b1, CRS, 1'b0, 1'b0);

    // R8: grant during a snoop does not complete
    step(OL, FF, 1'b1, CRS, CC, 1'b1);
    check("R8 gnt with snoop", {31'd0, cpuDone}, 32'd0);

    // R1: reset clears a dirty line
    step(OS, AA, 1'b0, C0, Z, 1'b1);
    @(negedge clk); rstN = 1'b0; cpuOp = ON; busGnt = 1'b0; snoopValid = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    #4;
    checkOuts("R1 after reset", 1'b0, C0, 1'b0, 1'b0);
    step(OS, AA, 1'b0, C0, Z, 1'b0);
    checkOuts("R1 line cleared", 1'b1, CRX, 1'b0, 1'b0);
    step(ON, Z, 1'b0, C0, Z, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule